// File: doc/BRIEF.md
# Speculation-Aware Register File with Deferred Faults

This block is a register file in which every entry carries a poison flag next to its data. Speculative instructions can be moved ahead of branches without trapping too early. When such an instruction hits an exception that would end the program, its writeback does not trap. It commits with the destination marked poisoned, and the fault is raised later, only if the value is actually used.

Exceptions that can be resumed, such as a missing page, are handed on to be serviced even when the instruction is speculative, because servicing them costs only time. On the consumer side, a non-speculative operation that reads a poisoned source raises a fatal fault. A speculative operation that reads one raises no fault and passes the poison on to its own result. A check operation placed where the hoisted instruction originally stood asks for recovery if its register is poisoned, and reports a clean completion otherwise.

Top module: `poison_rf`

## Requirements
- R1: After reset, every register reads back with its poison flag clear and its data zero.
- R2: A writeback with exception code 00 stores its data on the clock edge and clears the poison flag (unless R7 applies). The value is then visible on either read port from the next cycle.
- R3: A read from the register being committed in the same cycle returns the data and poison flag being written, not the old contents.
- R4: A speculative writeback (wr_spec=1) with a fatal exception code (10 or 11) commits zero data with the poison flag set, and exc_fwd_o stays 00.
- R5: A writeback with exception code 01 (resumable) leaves the register file unchanged and shows 01 on exc_fwd_o, whether or not it is speculative.
- R6: A non-speculative writeback with a fatal exception code leaves the register file unchanged and shows 10 on exc_fwd_o.
- R7: A speculative writeback with no exception and wr_src_poison=1 stores its data with the poison flag set. A non-speculative writeback ignores wr_src_poison.
- R8: A plain operation (op_kind 01) asserts fault_o when the register on port A is poisoned, or when the register on port B is poisoned and op_use_b=1. A poisoned port B is ignored when op_use_b=0.
- R9: A check operation (op_kind 11) tests the register on port A. It asserts recover_o if that register is poisoned and chk_ok_o if it is clean, and it never asserts fault_o.
- R10: A speculative operation (op_kind 10) that reads a poisoned source asserts spec_poison_o and never asserts fault_o.
- R11: At most one of fault_o, recover_o and chk_ok_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writeback valid |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | 64 | Result data |
| wr_spec | input | 1 | Writeback comes from a speculative instruction |
| wr_src_poison | input | 1 | The instruction read a poisoned source (from spec_poison_o) |
| wr_exc | input | 2 | Exception code: 00 none, 01 resumable, 10/11 fatal |
| exc_fwd_o | output | 2 | Exception passed on for servicing (00 when none or deferred) |
| rd_a_addr | input | 5 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_poison | output | 1 | Read port A poison flag |
| rd_b_addr | input | 5 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_poison | output | 1 | Read port B poison flag |
| op_kind | input | 2 | Consumer: 00 idle, 01 plain, 10 speculative, 11 check |
| op_use_b | input | 1 | Consumer reads port B as well |
| fault_o | output | 1 | Fatal fault: poisoned value consumed non-speculatively |
| recover_o | output | 1 | Check found its register poisoned |
| chk_ok_o | output | 1 | Check found its register clean |
| spec_poison_o | output | 1 | Speculative consumer must poison its result |

## Verification
The bench builds the block with its default values: 32 registers of 64 bits. This lets it write to both the lowest and the highest register index and use full-width data patterns, so a truncated index or a dropped upper data bit would show up. With the real register count, the bench can also keep a poisoned register and a clean register alive side by side while consumer operations read them, and confirm that a bypass on one index does not disturb the other.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

    typedef enum logic [1:0] {
        EXC_NONE      = 2'b00,
        EXC_RESUME    = 2'b01,
        EXC_FATAL     = 2'b10,
        EXC_FATAL_ALT = 2'b11
    } exc_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_PLAIN = 2'b01,
        OP_SPEC  = 2'b10,
        OP_CHECK = 2'b11
    } op_e;

    typedef struct packed {
        logic commit;
        logic poison;
        logic zero_data;
        exc_e fwd;
    } wb_ctl_t;

    typedef struct packed {
        logic fault;
        logic recover;
        logic chk_ok;
        logic spec_poison;
    } use_res_t;

    function automatic logic is_fatal(exc_e e);
        return e[1];
    endfunction

endpackage

// File: rtl/prf_wb_classify.sv
module prf_wb_classify
    import poison_rf_pkg::*;
(
    input  logic    wr_en,
    input  logic    wr_spec,
    input  logic    wr_src_poison,
    input  exc_e    wr_exc,
    output wb_ctl_t ctl
);
    always_comb begin
        ctl = '{commit: 1'b0, poison: 1'b0, zero_data: 1'b0, fwd: EXC_NONE};
        if (wr_en) begin
            unique case (1'b1)
                (wr_exc == EXC_NONE): begin
                    ctl.commit = 1'b1;
                    ctl.poison = wr_spec & wr_src_poison;
                end
                (wr_exc == EXC_RESUME): begin
                    ctl.fwd = EXC_RESUME;
                end
                default: begin
                    if (wr_spec) begin
                        ctl.commit    = 1'b1;
                        ctl.poison    = 1'b1;
                        ctl.zero_data = 1'b1;
                    end else begin
                        ctl.fwd = EXC_FATAL;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
    parameter int NREGS = 32,
    parameter int DW    = 64,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wpoison,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata,
    output logic [NRD-1:0]           rpoison
);
    logic [DW-1:0] mem_q  [NREGS];
    logic          pois_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i]  <= '0;
                pois_q[i] <= 1'b0;
            end
        end else if (we) begin
            mem_q[waddr]  <= wdata;
            pois_q[waddr] <= wpoison;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic hit;
        assign hit = we && (waddr == raddr[p]);
        always_comb begin
            if (hit) begin
                rdata[p]   = wdata;
                rpoison[p] = wpoison;
            end else begin
                rdata[p]   = mem_q[raddr[p]];
                rpoison[p] = pois_q[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/prf_consumer.sv
module prf_consumer
    import poison_rf_pkg::*;
(
    input  op_e      kind,
    input  logic     use_b,
    input  logic     pois_a,
    input  logic     pois_b,
    output use_res_t res
);
    logic src_bad;
    assign src_bad = pois_a | (use_b & pois_b);

    always_comb begin
        res = '0;
        unique case (kind)
            OP_PLAIN: res.fault       = src_bad;
            OP_SPEC:  res.spec_poison = src_bad;
            OP_CHECK: begin
                res.recover = pois_a;
                res.chk_ok  = ~pois_a;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/poison_rf.sv
module poison_rf
    import poison_rf_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int DW    = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_spec,
    input  logic          wr_src_poison,
    input  logic [1:0]    wr_exc,
    output logic [1:0]    exc_fwd_o,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_poison,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_poison,
    input  logic [1:0]    op_kind,
    input  logic          op_use_b,
    output logic          fault_o,
    output logic          recover_o,
    output logic          chk_ok_o,
    output logic          spec_poison_o
);
    wb_ctl_t             ctl;
    use_res_t            res;
    logic [1:0][AW-1:0]  raddr;
    logic [1:0][DW-1:0]  rdata;
    logic [1:0]          rpois;
    logic [DW-1:0]       wdata_eff;

    prf_wb_classify u_cls (
        .wr_en         (wr_en),
        .wr_spec       (wr_spec),
        .wr_src_poison (wr_src_poison),
        .wr_exc        (exc_e'(wr_exc)),
        .ctl           (ctl)
    );

    assign wdata_eff = ctl.zero_data ? '0 : wr_data;
    assign raddr     = {rd_b_addr, rd_a_addr};

    prf_storage #(.NREGS(NREGS), .DW(DW), .NRD(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.commit),
        .waddr   (wr_addr),
        .wdata   (wdata_eff),
        .wpoison (ctl.poison),
        .raddr   (raddr),
        .rdata   (rdata),
        .rpoison (rpois)
    );

    prf_consumer u_use (
        .kind   (op_e'(op_kind)),
        .use_b  (op_use_b),
        .pois_a (rpois[0]),
        .pois_b (rpois[1]),
        .res    (res)
    );

    assign rd_a_data     = rdata[0];
    assign rd_b_data     = rdata[1];
    assign rd_a_poison   = rpois[0];
    assign rd_b_poison   = rpois[1];
    assign exc_fwd_o     = ctl.fwd;
    assign fault_o       = res.fault;
    assign recover_o     = res.recover;
    assign chk_ok_o      = res.chk_ok;
    assign spec_poison_o = res.spec_poison;
endmodule

// File: rtl/poison_rf_chk.sv
module poison_rf_chk #(
    parameter int NREGS = 32,
    parameter int DW    = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_spec,
    input logic          wr_src_poison,
    input logic [1:0]    wr_exc,
    input logic [1:0]    exc_fwd_o,
    input logic [AW-1:0] rd_a_addr,
    input logic [DW-1:0] rd_a_data,
    input logic          rd_a_poison,
    input logic [AW-1:0] rd_b_addr,
    input logic [DW-1:0] rd_b_data,
    input logic          rd_b_poison,
    input logic [1:0]    op_kind,
    input logic          op_use_b,
    input logic          fault_o,
    input logic          recover_o,
    input logic          chk_ok_o,
    input logic          spec_poison_o
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (!rd_a_poison && !rd_b_poison));

    a_r2_holds_value: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_exc == 2'b00) |=>
        ((rd_a_addr != $past(wr_addr)) || (wr_en && wr_addr == rd_a_addr) ||
         (rd_a_data == $past(wr_data))));

    a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_exc == 2'b00 && rd_a_addr == wr_addr) |->
        (rd_a_data == wr_data && rd_a_poison == (wr_spec & wr_src_poison)));

    a_r4_deferred: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_spec && wr_exc[1]) |-> (exc_fwd_o == 2'b00));

    a_r6_nonspec_fatal: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_spec && wr_exc[1]) |-> (exc_fwd_o == 2'b10));

    a_r8_plain_fault: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'b01 && rd_a_poison) |-> fault_o);

    a_r9_check_no_fault: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'b11) |-> (!fault_o && (recover_o == rd_a_poison)));

    a_r10_spec_no_fault: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'b10) |-> !fault_o);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({fault_o, recover_o, chk_ok_o}) <= 1);
endmodule

bind poison_rf poison_rf_chk #(.NREGS(NREGS), .DW(DW)) u_chk (.*);

// File: tb/poison_rf_tb.sv
module poison_rf_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_spec, wr_src_poison, op_use_b;
    logic [4:0]  wr_addr, rd_a_addr, rd_b_addr;
    logic [63:0] wr_data, rd_a_data, rd_b_data;
    logic [1:0]  wr_exc, exc_fwd_o, op_kind;
    logic        rd_a_poison, rd_b_poison, fault_o, recover_o, chk_ok_o, spec_poison_o;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [63:0] PAT_A = 64'hDEAD_BEEF_0123_4567;
    localparam logic [63:0] PAT_B = 64'h8000_0000_0000_0001;
    localparam logic [63:0] PAT_C = 64'h5A5A_A5A5_FFFF_0000;

    always #5 clk = ~clk;

    poison_rf dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_spec = 0; wr_src_poison = 0; wr_exc = 2'b00; wr_addr = '0;
        wr_data = '0; op_kind = 2'b00; op_use_b = 0;
    endtask

    task automatic wb(input logic [4:0] a, input logic [63:0] d, input logic s,
                      input logic sp, input logic [1:0] e);
        @(negedge clk);
        idle();
        wr_en = 1; wr_addr = a; wr_data = d; wr_spec = s; wr_src_poison = sp; wr_exc = e;
    endtask

    task automatic rd(input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        idle();
        rd_a_addr = a; rd_b_addr = b;
        #2;
    endtask

    task automatic t_reset();
        rd(5'd0, 5'd31);
        chk("R1 poison a", {63'd0, rd_a_poison}, 64'd0);
        chk("R1 poison b", {63'd0, rd_b_poison}, 64'd0);
        chk("R1 data b", rd_b_data, 64'd0);
    endtask

    task automatic t_clean_write();
        wb(5'd5, PAT_A, 0, 0, 2'b00);
        wb(5'd31, PAT_B, 0, 0, 2'b00);
        rd(5'd31, 5'd5);
        chk("R2 data a", rd_a_data, PAT_B);
        chk("R2 data b", rd_b_data, PAT_A);
        chk("R2 poison a", {63'd0, rd_a_poison}, 64'd0);
    endtask

    task automatic t_bypass();
        wb(5'd7, PAT_C, 0, 0, 2'b00);
        rd_a_addr = 5'd7; rd_b_addr = 5'd5;
        #2;
        chk("R3 bypass data", rd_a_data, PAT_C);
        chk("R3 other port", rd_b_data, PAT_A);
        wb(5'd8, PAT_B, 1, 1, 2'b00);
        rd_a_addr = 5'd8;
        #2;
        chk("R3 bypass poison", {63'd0, rd_a_poison}, 64'd1);
    endtask

    task automatic t_spec_fatal();
        wb(5'd9, PAT_C, 1, 0, 2'b10);
        #2;
        chk("R4 no forward", {62'd0, exc_fwd_o}, 64'd0);
        wb(5'd12, PAT_C, 1, 0, 2'b11);
        rd(5'd9, 5'd12);
        chk("R4 poison", {63'd0, rd_a_poison}, 64'd1);
        chk("R4 data zero", rd_a_data, 64'd0);
        chk("R4 code 11 poison", {63'd0, rd_b_poison}, 64'd1);
    endtask

    task automatic t_resumable();
        wb(5'd5, PAT_C, 1, 0, 2'b01);
        #2;
        chk("R5 spec forward", {62'd0, exc_fwd_o}, 64'd1);
        wb(5'd5, PAT_B, 0, 0, 2'b01);
        #2;
        chk("R5 nonspec forward", {62'd0, exc_fwd_o}, 64'd1);
        rd(5'd5, 5'd5);
        chk("R5 unchanged", rd_a_data, PAT_A);
        chk("R5 not poisoned", {63'd0, rd_a_poison}, 64'd0);
    endtask

    task automatic t_nonspec_fatal();
        wb(5'd5, PAT_C, 0, 0, 2'b10);
        #2;
        chk("R6 forward fatal", {62'd0, exc_fwd_o}, 64'd2);
        rd(5'd5, 5'd0);
        chk("R6 unchanged", rd_a_data, PAT_A);
        chk("R6 not poisoned", {63'd0, rd_a_poison}, 64'd0);
    endtask

    task automatic t_propagate();
        wb(5'd10, PAT_B, 1, 1, 2'b00);
        wb(5'd11, PAT_C, 0, 1, 2'b00);
        rd(5'd10, 5'd11);
        chk("R7 data kept", rd_a_data, PAT_B);
        chk("R7 poison set", {63'd0, rd_a_poison}, 64'd1);
        chk("R7 nonspec ignores", {63'd0, rd_b_poison}, 64'd0);
        wb(5'd10, PAT_A, 0, 0, 2'b00);
        rd(5'd10, 5'd0);
        chk("R2 clears poison", {63'd0, rd_a_poison}, 64'd0);
    endtask

    task automatic t_consumers();
        rd(5'd9, 5'd5); op_kind = 2'b01; #1;
        chk("R8 fault on a", {63'd0, fault_o}, 64'd1);
        rd(5'd5, 5'd9); op_kind = 2'b01; op_use_b = 0; #1;
        chk("R8 b ignored", {63'd0, fault_o}, 64'd0);
        op_use_b = 1; #1;
        chk("R8 fault on b", {63'd0, fault_o}, 64'd1);
        rd(5'd9, 5'd5); op_kind = 2'b11; #1;
        chk("R9 recover", {61'd0, fault_o, recover_o, chk_ok_o}, 64'b010);
        rd(5'd5, 5'd9); op_kind = 2'b11; op_use_b = 1; #1;
        chk("R9 clean check", {61'd0, fault_o, recover_o, chk_ok_o}, 64'b001);
        rd(5'd5, 5'd9); op_kind = 2'b10; op_use_b = 1; #1;
        chk("R10 propagate", {62'd0, spec_poison_o, fault_o}, 64'b10);
        rd(5'd5, 5'd7); op_kind = 2'b10; op_use_b = 1; #1;
        chk("R10 clean spec", {62'd0, spec_poison_o, fault_o}, 64'b00);
        rd(5'd9, 5'd9); op_kind = 2'b00; #1;
        chk("R11 idle quiet", {61'd0, fault_o, recover_o, chk_ok_o}, 64'b000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle();
        rd_a_addr = '0; rd_b_addr = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_clean_write();
        t_bypass();
        t_spec_fatal();
        t_resumable();
        t_nonspec_fatal();
        t_propagate();
        t_consumers();
        @(negedge clk);
        idle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule